// File: doc/BRIEF.md
# Local-Bus Receive to Stream Bridge

This bridge sits behind a wide packet receiver. It takes packet segments carried on a 512-bit word and presents them as an AXI4-Stream style beat stream. On the input side, an enable qualifies each cycle. The start marker, end marker and channel number only count in qualified cycles. The error flag and the empty-byte count only count in qualified cycles that also carry the end marker.

The bridge registers each qualified input cycle into one output beat, one cycle later. On the last beat of a packet it turns the empty-byte count into a byte-keep mask and passes the error flag on `m_tuser`. The channel number is placed on `m_tdest` for every beat.

A small framing tracker watches the qualified markers and the channel. It raises a sticky violation flag when the framing is broken. The output has no ready input, because the receiver cannot be stalled.

Top module: `lbus_rx_to_stream`

## Requirements
- R1: After a synchronous active-high reset, `m_tvalid`, `m_tlast`, `m_tuser` and `proto_violation` are 0.
- R2: `m_tvalid` equals `in_en` delayed by one clock. On a beat, `m_tdata` equals `in_data`, `m_tdest` equals `in_chan` and `m_tlast` equals `in_eop`, all taken from the qualified cycle.
- R3: In a cycle with `in_en` low, every other input is ignored. No beat is produced, `m_tdata`, `m_tkeep`, `m_tlast`, `m_tuser` and `m_tdest` keep their values, and the violation flag does not change.
- R4: On a beat whose qualified cycle had `in_eop` low, `m_tkeep` is all ones, whatever `in_empty` holds.
- R5: On a last beat, `m_tkeep` bit i covers `m_tdata[8i+7:8i]`. The first byte of the word sits in lane 63 (bits 511:504). Bit i is 0 exactly when i < `in_empty`, so the empty count clears the lowest-order lanes.
- R6: `m_tuser` equals `in_err` on a last beat and is 0 on every other beat, even if `in_err` was high on that beat.
- R7: On an errored last beat, the empty count is a multiple of 8, and the same R5 mask rule applies to it.
- R8: A qualified cycle without a start marker while no packet is open sets `proto_violation`. It is visible on the same beat.
- R9: A qualified start marker while a packet is open sets `proto_violation`. The new start opens a new packet.
- R10: A qualified non-start cycle inside an open packet whose channel differs from the channel captured at the start sets `proto_violation`.
- R11: `proto_violation` stays set until reset, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_en | input | 1 | Qualifies all other inputs in this cycle |
| in_sop | input | 1 | Start of packet, counted when in_en is high |
| in_eop | input | 1 | End of packet, counted when in_en is high |
| in_err | input | 1 | Packet error, counted when in_en and in_eop are high |
| in_empty | input | 6 | Unused bytes in the last word, counted when in_en and in_eop are high |
| in_chan | input | 8 | Channel of the packet in flight |
| in_data | input | 512 | Data word, first byte in bits 511:504 |
| m_tvalid | output | 1 | Output beat valid |
| m_tdata | output | 512 | Output data |
| m_tkeep | output | 64 | Byte keep, bit i for bits 8i+7:8i |
| m_tlast | output | 1 | Last beat of packet |
| m_tuser | output | 1 | Error flag on the last beat |
| m_tdest | output | 8 | Channel of the beat |
| proto_violation | output | 1 | Sticky framing violation flag |

## Verification
The assertions assume that the qualified error case only arrives with an empty count whose low three bits are zero. The bench only drives errored last beats with counts of 0, 8, 24 and 56.

The assertions also assume reset is held for at least one clock before any qualified traffic. The bench keeps `in_en` low throughout every reset.

In idle cycles the bench drives arbitrary values on every qualified field. This shows that the hold and flag assertions cover inputs that are not well behaved.

// File: rtl/lbus_rx_to_stream.sv
module lbus_rx_to_stream #(
  parameter int DATA_BYTES = 64,
  parameter int CHAN_W     = 8,
  localparam int DATA_W    = DATA_BYTES * 8,
  localparam int EMPTY_W   = $clog2(DATA_BYTES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_en,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic               in_err,
  input  logic [EMPTY_W-1:0] in_empty,
  input  logic [CHAN_W-1:0]  in_chan,
  input  logic [DATA_W-1:0]  in_data,
  output logic               m_tvalid,
  output logic [DATA_W-1:0]  m_tdata,
  output logic [DATA_BYTES-1:0] m_tkeep,
  output logic               m_tlast,
  output logic               m_tuser,
  output logic [CHAN_W-1:0]  m_tdest,
  output logic               proto_violation
);

  logic              in_pkt;
  logic [CHAN_W-1:0] open_chan;
  logic [DATA_BYTES-1:0] last_keep;
  logic orphan, dup_sop, chan_jump;

  assign last_keep = {DATA_BYTES{1'b1}} << in_empty;
  assign orphan    = in_en & ~in_pkt & ~in_sop;
  assign dup_sop   = in_en &  in_pkt &  in_sop;
  assign chan_jump = in_en &  in_pkt & ~in_sop & (in_chan != open_chan);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_tvalid        <= 1'b0;
      m_tdata         <= '0;
      m_tkeep         <= '0;
      m_tlast         <= 1'b0;
      m_tuser         <= 1'b0;
      m_tdest         <= '0;
      in_pkt          <= 1'b0;
      open_chan       <= '0;
      proto_violation <= 1'b0;
    end else begin
      m_tvalid <= in_en;
      if (in_en) begin
        m_tdata <= in_data;
        m_tkeep <= in_eop ? last_keep : {DATA_BYTES{1'b1}};
        m_tlast <= in_eop;
        m_tuser <= in_eop & in_err;
        m_tdest <= in_chan;
        in_pkt  <= (in_pkt | in_sop) & ~in_eop;
        if (in_sop) open_chan <= in_chan;
      end
      if (orphan | dup_sop | chan_jump) proto_violation <= 1'b1;
    end
  end

  a_r2_valid_follows_en: assert property (@(posedge clk) disable iff (rst)
    in_en |=> m_tvalid);
  a_r3_no_beat_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_en |=> !m_tvalid);
  a_r3_data_held_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_en |=> $stable(m_tdata) && $stable(m_tdest));
  a_r4_full_keep_midpacket: assert property (@(posedge clk) disable iff (rst)
    in_en && !in_eop |=> &m_tkeep);
  a_r5_first_lane_kept: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> m_tkeep[DATA_BYTES-1]);
  a_r6_user_only_on_last: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tlast |-> !m_tuser);
  a_r9_restart_flagged: assert property (@(posedge clk) disable iff (rst)
    in_en && in_sop && in_pkt |=> proto_violation);
  a_r11_violation_sticky: assert property (@(posedge clk) disable iff (rst)
    proto_violation |=> proto_violation);

endmodule

// File: tb/lbus_rx_to_stream_tb.sv
module lbus_rx_to_stream_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_en = 0, in_sop = 0, in_eop = 0, in_err = 0;
  logic [5:0] in_empty = '0;
  logic [7:0] in_chan = '0;
  logic [511:0] in_data = '0;
  logic m_tvalid, m_tlast, m_tuser, proto_violation;
  logic [511:0] m_tdata;
  logic [63:0] m_tkeep;
  logic [7:0] m_tdest;

  lbus_rx_to_stream dut_i (
    .clk(clk), .rst(rst), .in_en(in_en), .in_sop(in_sop), .in_eop(in_eop),
    .in_err(in_err), .in_empty(in_empty), .in_chan(in_chan), .in_data(in_data),
    .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
    .m_tuser(m_tuser), .m_tdest(m_tdest), .proto_violation(proto_violation));

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;

  bit ev, elast, euser, eviol, mpkt;
  logic [511:0] edata;
  logic [63:0] ekeep;
  logic [7:0] edest, mchan;

  task automatic chk(string req, string what, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string vtag);
    chk("R2", "tvalid", m_tvalid, ev);
    chk("R2", "tdata", m_tdata, edata);
    chk("R2", "tdest", m_tdest, edest);
    chk("R2", "tlast", m_tlast, elast);
    chk(elast ? "R5" : "R4", "tkeep", m_tkeep, ekeep);
    chk("R6", "tuser", m_tuser, euser);
    chk(vtag, "violation", proto_violation, eviol);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_en = 0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    ev = 0; elast = 0; euser = 0; eviol = 0; mpkt = 0;
    edata = '0; ekeep = '0; edest = '0; mchan = '0;
  endtask

  task automatic step(bit en, bit sop, bit eop, bit err, int empty, int chan,
                      logic [31:0] seed, string vtag);
    in_en = en; in_sop = sop; in_eop = eop; in_err = err;
    in_empty = 6'(empty); in_chan = 8'(chan); in_data = {16{seed}};
    ev = en;
    if (en) begin
      if (!mpkt && !sop) eviol = 1;
      if (mpkt && sop) eviol = 1;
      if (mpkt && !sop && chan != int'(mchan)) eviol = 1;
      if (sop) mchan = 8'(chan);
      mpkt = (mpkt || sop) && !eop;
      edata = {16{seed}};
      edest = 8'(chan);
      elast = eop;
      euser = eop && err;
      for (int i = 0; i < 64; i++) ekeep[i] = eop ? (i >= empty) : 1'b1;
    end
    @(posedge clk); @(negedge clk);
    compare(vtag);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    compare("R1");
    // R2 R4 R5: three-beat packet, full last word
    step(1,1,0,0,17,5,32'h1111_0001,"R2");
    step(1,0,0,1,9,5,32'h1111_0002,"R6");
    step(1,0,1,0,0,5,32'h1111_0003,"R5");
    // R5: single-beat packet, 13 empty bytes
    step(1,1,1,0,13,9,32'h2222_0001,"R5");
    // R3: idle cycles with garbage on every qualified field
    step(0,0,1,1,33,77,32'hdead_beef,"R3");
    step(0,1,1,0,7,3,32'hbad0_0001,"R3");
    step(0,0,0,1,63,200,32'hbad0_0002,"R3");
    // R6 R7: errored packet, empty 24 (multiple of 8)
    step(1,1,0,1,0,12,32'h3333_0001,"R6");
    step(0,0,0,0,0,0,32'h0,"R3");
    step(1,0,1,1,24,12,32'h3333_0002,"R7");
    step(1,1,1,1,56,4,32'h3333_0003,"R7");
    step(1,1,1,1,8,4,32'h3333_0004,"R7");
    step(1,1,1,0,63,6,32'h4444_0001,"R5");
    step(1,1,1,1,0,6,32'h4444_0002,"R6");
    // R8: orphan beat
    step(1,0,0,0,0,3,32'h5555_0001,"R8");
    // R11: sticky across good traffic
    step(1,1,0,0,0,3,32'h5555_0002,"R11");
    step(1,0,1,0,4,3,32'h5555_0003,"R11");
    step(0,0,0,0,0,0,32'h0,"R11");
    do_reset();
    compare("R11");
    // R9: start while open
    step(1,1,0,0,0,7,32'h6666_0001,"R9");
    step(1,1,0,0,0,8,32'h6666_0002,"R9");
    step(1,0,1,0,2,8,32'h6666_0003,"R9");
    do_reset();
    compare("R1");
    // R3: idle sop/eop do not open or close a packet
    step(0,1,0,0,0,2,32'h7777_0000,"R3");
    step(1,1,0,0,0,2,32'h7777_0001,"R3");
    step(0,0,1,0,0,9,32'h7777_0002,"R3");
    step(1,0,1,0,1,2,32'h7777_0003,"R3");
    // R10: channel changes mid-packet
    step(1,1,0,0,0,10,32'h8888_0001,"R10");
    step(1,0,0,0,0,11,32'h8888_0002,"R10");
    step(1,0,1,0,5,11,32'h8888_0003,"R10");
    step(0,0,0,0,0,0,32'h0,"R11");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule